// File: doc/BRIEF.md
# Memory Field Byte Search Engine

This block looks for the first occurrence of a model byte inside a field of memory and writes an address derived from the outcome into index register 7. Register 7 is held in memory as two bytes at addresses 0x00FE (high byte) and 0x00FF (low byte). The field is given by its leftmost address and a 16-bit byte count. A direction input selects an ascending scan (search right) or a descending scan starting at the rightmost byte (search left).

After a `start` pulse the engine reads one byte per cycle through a synchronous read port, where data returns the cycle after the request. It stops at the first byte equal to the model. It then stores the 16-bit result with two byte writes and raises `done` for one cycle. The stored address always lies one step beyond the match in the scan direction. When nothing matches, it is the first address outside the field in that direction. The block has no flag or condition output.

The control is a four-state machine:
- **S_IDLE**: waits for `start`. The transition IDLE→SCAN latches the field, length, model and direction.
- **S_SCAN**: issues reads and compares returned bytes. The transition SCAN→STORE is taken on a match or when all bytes have been requested and checked.
- **S_STORE**: writes the result bytes, most significant first. The transition STORE→DONE follows the last byte.
- **S_DONE**: pulses `done`. The transition DONE→IDLE is unconditional.

Top module: `field_scan`

## Requirements
- R1: Search right (`dir_left`=0) reads addresses `field`, `field+1`, … in ascending order. It stops at the first byte equal to `model`. For a match at offset i it stores `field+i+1`.
- R2: Search right with no match in `len` bytes stores `field+len`.
- R3: Search left (`dir_left`=1) reads the same field in descending order starting at `field+len-1`. It stops at the first match. For a match at offset i (counted from the leftmost byte) it stores `field+i-1`.
- R4: Search left with no match stores `field-1`.
- R5: A length of zero issues no read and is treated as not found: right stores `field`, left stores `field-1`.
- R6: All address arithmetic, for both the scan and the result, wraps modulo 2^16.
- R7: The result is written as two single-cycle byte writes on consecutive cycles: bits 15:8 to 0x00FE, then bits 7:0 to 0x00FF. `done` is high for exactly one cycle, in the cycle after the second write.
- R8: At most one read is issued per cycle, with data taken the following cycle. The number of reads equals the number of bytes examined: match position plus one, or `len` when nothing matches. The first match wins even when several bytes match.
- R9: After reset `busy`, `done`, `mem_rd_en` and `mem_wr_en` are low. A `start` seen while `busy` is high has no effect on the operation in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a search (sampled in idle only) |
| dir_left | input | 1 | 0 = search right (ascending), 1 = search left (descending) |
| field_base | input | 16 | Address of the leftmost byte of the field |
| field_len | input | 16 | Number of bytes in the field |
| model | input | 8 | Byte value searched for |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_rd_en | output | 1 | Read request |
| mem_rd_addr | output | 16 | Read address |
| mem_rd_data | input | 8 | Read data, valid the cycle after the request |
| mem_wr_en | output | 1 | Write strobe |
| mem_wr_addr | output | 16 | Write address |
| mem_wr_data | output | 8 | Write data |

## Verification
The model memory holds a byte pattern in which each value occurs once per 256 addresses. This places every match at a known offset. Searches are run in both directions with the match at the first byte scanned, at the last byte scanned and in the middle, and with no match at all. These cases separate the one-step-beyond rule from the two different not-found addresses. Zero-length fields and fields crossing 0xFFFF→0x0000 expose missing wraparound and stray reads. A field longer than 256 bytes contains several matches and shows whether the engine stops at the first one in its own direction. The count of issued reads reveals scans that overrun or stop early.

// File: rtl/field_scan_pkg.sv
package field_scan_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SCAN  = 2'd1,
        S_STORE = 2'd2,
        S_DONE  = 2'd3
    } scan_state_e;

endpackage

// File: rtl/scan_pointer.sv
// Walks the field in the chosen direction and counts requested bytes.
module scan_pointer #(
    parameter int unsigned AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          left_in,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic          step,
    output logic [AW-1:0] ptr,
    output logic          left_q,
    output logic          exhausted
);
    localparam logic [AW-1:0] ONE = AW'(1);

    logic [AW-1:0] cnt;
    logic [AW-1:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr    <= '0;
            cnt    <= '0;
            len_q  <= '0;
            left_q <= 1'b0;
        end else if (load) begin
            // left scans begin at the rightmost byte; wraps modulo 2^AW (R6)
            ptr    <= left_in ? (base + len - ONE) : base;
            cnt    <= '0;
            len_q  <= len;
            left_q <= left_in;
        end else if (step) begin
            ptr <= left_q ? (ptr - ONE) : (ptr + ONE);
            cnt <= cnt + ONE;
        end
    end

    assign exhausted = (cnt == len_q);

    // never requests more bytes than the field holds (R8)
    p_count_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= len_q);

    // no step once every byte has been requested (R8)
    p_no_overrun_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exhausted && !load) |-> !step);

endmodule

// File: rtl/byte_match.sv
// Holds the outstanding read and compares the returned byte with the model.
module byte_match #(
    parameter int unsigned AW = 16,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] model_in,
    input  logic          issue,
    input  logic [AW-1:0] issue_addr,
    input  logic [DW-1:0] rd_data,
    output logic          hit,
    output logic [AW-1:0] hit_addr
);
    logic          pend;
    logic [DW-1:0] model_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend     <= 1'b0;
            hit_addr <= '0;
            model_q  <= '0;
        end else if (load) begin
            pend    <= 1'b0;
            model_q <= model_in;
        end else begin
            pend <= issue;
            if (issue) begin
                hit_addr <= issue_addr;
            end
        end
    end

    assign hit = pend && (rd_data == model_q);

    // a hit only ever refers to a read made the cycle before (R8)
    p_hit_needs_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(issue));

endmodule

// File: rtl/field_scan.sv
module field_scan
    import field_scan_pkg::*;
#(
    parameter int unsigned AW        = 16,
    parameter int unsigned DW        = 8,
    parameter int unsigned REG7_ADDR = 'h00FE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          dir_left,
    input  logic [15:0]   field_base,
    input  logic [15:0]   field_len,
    input  logic [7:0]    model,
    output logic          busy,
    output logic          done,
    output logic          mem_rd_en,
    output logic [15:0]   mem_rd_addr,
    input  logic [7:0]    mem_rd_data,
    output logic          mem_wr_en,
    output logic [15:0]   mem_wr_addr,
    output logic [7:0]    mem_wr_data
);
    localparam int unsigned    NB   = AW / DW;
    localparam int unsigned    IW   = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [AW-1:0]  R7A  = AW'(REG7_ADDR);
    localparam logic [AW-1:0]  ONE  = AW'(1);
    localparam logic [IW-1:0]  LAST = IW'(NB - 1);

    scan_state_e   state, state_nx;
    logic [AW-1:0] ptr;
    logic          left_q;
    logic          exhausted;
    logic          hit;
    logic [AW-1:0] hit_addr;
    logic          load;
    logic          step;
    logic          scan_end;
    logic [AW-1:0] result;
    logic [IW-1:0] wr_idx;

    assign load     = (state == S_IDLE) && start;
    assign step     = (state == S_SCAN) && !exhausted && !hit;
    assign scan_end = hit || exhausted;

    scan_pointer #(.AW(AW)) i_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .left_in   (dir_left),
        .base      (field_base),
        .len       (field_len),
        .step      (step),
        .ptr       (ptr),
        .left_q    (left_q),
        .exhausted (exhausted)
    );

    byte_match #(.AW(AW), .DW(DW)) i_match (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .model_in   (model),
        .issue      (step),
        .issue_addr (ptr),
        .rd_data    (mem_rd_data),
        .hit        (hit),
        .hit_addr   (hit_addr)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (start)           state_nx = S_SCAN;
            S_SCAN:  if (scan_end)        state_nx = S_STORE;
            S_STORE: if (wr_idx == LAST)  state_nx = S_DONE;
            S_DONE:                       state_nx = S_IDLE;
            default:                      state_nx = S_IDLE;
        endcase
    end

    // result capture and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            result <= '0;
            wr_idx <= '0;
        end else begin
            if (state == S_SCAN && scan_end) begin
                // one step beyond the match, else the pointer already sits past the field
                if (hit) begin
                    result <= left_q ? (hit_addr - ONE) : (hit_addr + ONE);
                end else begin
                    result <= ptr;
                end
            end
            if (state == S_STORE) begin
                wr_idx <= (wr_idx == LAST) ? '0 : wr_idx + IW'(1);
            end else begin
                wr_idx <= '0;
            end
        end
    end

    // outputs
    always_comb begin
        busy        = (state != S_IDLE);
        done        = (state == S_DONE);
        mem_rd_en   = step;
        mem_rd_addr = ptr;
        mem_wr_en   = (state == S_STORE);
        mem_wr_addr = R7A + AW'(wr_idx);
        mem_wr_data = DW'(result >> (DW * (NB - 1 - int'(wr_idx))));
    end

    // reads and writes never share a cycle (R8)
    p_port_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd_en && mem_wr_en));

    // writes only land on register 7 bytes (R7)
    p_write_target_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> (mem_wr_addr - R7A) < AW'(NB));

    // later bytes follow the previous one on the cycle before (R7)
    p_write_order_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_wr_en && mem_wr_addr != R7A) |->
            ($past(mem_wr_en) && $past(mem_wr_addr) == mem_wr_addr - ONE));

    // done follows the last byte write and lasts one cycle (R7)
    p_done_after_store_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($past(mem_wr_en) && $past(mem_wr_addr) == R7A + AW'(NB - 1)));

    p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // nothing moves on the memory ports while idle (R9)
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !mem_wr_en));

endmodule

// File: tb/test_field_scan.sv
module test_field_scan;

    typedef struct packed {
        logic [15:0] field;
        logic [15:0] len;
        logic [7:0]  model;
        logic        left;
        logic [15:0] exp_res;
        logic [15:0] exp_rd;
        logic [3:0]  req;
    } vec_t;

    // memory byte at address a is a[7:0]^0x5A, so 0x7A sits at low byte 0x20
    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{16'h1010, 16'h0020, 8'h7A, 1'b0, 16'h1021, 16'h0011, 4'd1}, // R1 mid
        '{16'h1010, 16'h0020, 8'h7A, 1'b1, 16'h101F, 16'h0010, 4'd3}, // R3 mid
        '{16'h1010, 16'h0010, 8'h7A, 1'b0, 16'h1020, 16'h0010, 4'd2}, // R2
        '{16'h1010, 16'h0010, 8'h7A, 1'b1, 16'h100F, 16'h0010, 4'd4}, // R4
        '{16'h1020, 16'h0004, 8'h7A, 1'b0, 16'h1021, 16'h0001, 4'd1}, // R1 first byte
        '{16'h101D, 16'h0004, 8'h7A, 1'b1, 16'h101F, 16'h0001, 4'd3}, // R3 rightmost byte
        '{16'h1020, 16'h0004, 8'h7A, 1'b1, 16'h101F, 16'h0004, 4'd3}, // R3 leftmost byte
        '{16'h1020, 16'h0000, 8'h7A, 1'b0, 16'h1020, 16'h0000, 4'd5}, // R5 right
        '{16'h1020, 16'h0000, 8'h7A, 1'b1, 16'h101F, 16'h0000, 4'd5}, // R5 left
        '{16'hFFF8, 16'h000C, 8'h58, 1'b0, 16'h0003, 16'h000B, 4'd6}, // R6 match past wrap
        '{16'h0000, 16'h0003, 8'h4A, 1'b1, 16'hFFFF, 16'h0003, 4'd6}, // R6 left miss
        '{16'hFFFE, 16'h0002, 8'h4A, 1'b0, 16'h0000, 16'h0002, 4'd6}, // R6 right miss
        '{16'h1000, 16'h0300, 8'h7A, 1'b0, 16'h1021, 16'h0021, 4'd8}, // R8 first of many
        '{16'h1000, 16'h0300, 8'h7A, 1'b1, 16'h121F, 16'h00E0, 4'd8}  // R8 first of many
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dir_left = 1'b0;
    logic [15:0] field_base = '0;
    logic [15:0] field_len = '0;
    logic [7:0]  model = '0;
    logic        busy, done;
    logic        mem_rd_en, mem_wr_en;
    logic [15:0] mem_rd_addr, mem_wr_addr;
    logic [7:0]  mem_rd_data, mem_wr_data;

    int checks = 0;
    int errors = 0;

    logic        clr = 1'b0;
    int          rd_cnt, wr_cnt;
    logic [15:0] wr_a0, wr_a1;
    logic [7:0]  wr_d0, wr_d1;

    always #4 clk = ~clk;

    field_scan i_field_scan (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .dir_left    (dir_left),
        .field_base  (field_base),
        .field_len   (field_len),
        .model       (model),
        .busy        (busy),
        .done        (done),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_data (mem_rd_data),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr),
        .mem_wr_data (mem_wr_data)
    );

    // synchronous read memory with computed contents
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem_rd_addr[7:0] ^ 8'h5A;
    end

    // port monitor
    always @(posedge clk) begin
        if (clr) begin
            rd_cnt <= 0;
            wr_cnt <= 0;
        end else begin
            if (mem_rd_en) rd_cnt <= rd_cnt + 1;
            if (mem_wr_en) begin
                if (wr_cnt == 0) begin wr_a0 <= mem_wr_addr; wr_d0 <= mem_wr_data; end
                if (wr_cnt == 1) begin wr_a1 <= mem_wr_addr; wr_d1 <= mem_wr_data; end
                wr_cnt <= wr_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wait_done(input string req, output bit ok);
        ok = 1'b0;
        for (int k = 0; k < 4000; k++) begin
            @(negedge clk);
            if (done) begin ok = 1'b1; break; end
        end
        if (!ok) check({req, " done timeout"}, 32'd0, 32'd1);
    endtask

    task automatic run_vec(input vec_t v, input bit poke_busy);
        string req;
        bit    ok;
        req = $sformatf("R%0d", v.req);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr        = 1'b0;
        field_base = v.field;
        field_len  = v.len;
        model      = v.model;
        dir_left   = v.left;
        start      = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (poke_busy) begin
            // R9: start while busy, with different operands
            @(negedge clk);
            field_base = 16'h2000;
            field_len  = 16'h0008;
            model      = 8'h00;
            dir_left   = ~v.left;
            start      = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        wait_done(req, ok);
        if (ok) begin
            check({req, " result"}, {16'd0, wr_d0, wr_d1}, {16'd0, v.exp_res});
            check({req, " R8 reads"}, rd_cnt, {16'd0, v.exp_rd});
            check({req, " R7 write count"}, wr_cnt, 32'd2);
            check({req, " R7 write order"}, {wr_a0, wr_a1}, {16'h00FE, 16'h00FF});
            @(negedge clk);
            check({req, " R7 done pulse"}, {30'd0, done, busy}, 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 reset outputs", {28'd0, busy, done, mem_rd_en, mem_wr_en}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R9 idle after reset", {28'd0, busy, done, mem_rd_en, mem_wr_en}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], 1'b0);
        end

        // R9 start during a running search is ignored
        run_vec(VECS[0], 1'b1);
        run_vec(VECS[3], 1'b1);

        // R5 zero-length search issues no read at all
        run_vec(VECS[7], 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule